// File: doc/BRIEF.md
# Banked Grid Neighbourhood Reader

This block keeps a two-dimensional grid of data words spread over a square array of independent RAM banks, by default four by four. It is built so that every rectangular neighbourhood the size of that bank array can be fetched in a single access, wherever it sits on the grid. A compute pipeline presents the grid coordinate of the neighbourhood's lower corner. Two cycles later it receives all sixteen words at once, in a fixed cluster order.

Each grid point is assigned to a bank by the low bits of its two coordinates. Inside that bank it sits at an address formed from the upper coordinate bits. When a neighbourhood is not aligned to the bank array, some banks must look one row or column further along. Every bank therefore works out its own address from the base coordinate, per axis, before the indices are flattened. A reordering stage then rotates the bank outputs into cluster position using the base's low bits.

The grid is loaded through a single-word write port. That port runs alongside the read path without stalling it, because each bank is a RAM with separate read and write ports.

Top module: `igc_cluster_mem`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` stays low until a read request has been accepted.
- R2: `rd_valid` is high in exactly those cycles that follow, by two rising clock edges, a cycle in which `rd_en` was high. It is low in all other cycles.
- R3: For a read at base (X, Y), cluster position p = i + 4*j (i, j in 0..3) appears in `rd_data[p*16 +: 16]`. It holds the grid word stored at (X+i, Y+j). This holds for any base whose whole neighbourhood lies inside the grid.
- R4: A base with both coordinates a multiple of 4 returns the sixteen words of that aligned 4x4 tile.
- R5: A base with non-zero low bits returns a neighbourhood that straddles tile boundaries in X, Y or both, without conflict or wrong data. Banks whose index is below the base's low bits read the next tile along that axis.
- R6: A write with `wr_en` high stores `wr_data` at (`wr_x`, `wr_y`) only. Every other grid word is left unchanged.
- R7: Reads and writes issued in the same cycles, back to back, do not disturb one another. Each read returns the grid contents its request was entitled to under R8.
- R8: A write presented in the same cycle as a read request is seen by that read. A write presented one cycle after the request is not seen; the read returns the older word.
- R9: When `wr_en` is low, the values on `wr_x`, `wr_y` and `wr_data` have no effect on the stored grid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| rd_en | input | 1 | Read request for the neighbourhood at (`rd_x`, `rd_y`) |
| rd_x | input | 5 | Base X coordinate of the neighbourhood ($clog2(GX)) |
| rd_y | input | 5 | Base Y coordinate of the neighbourhood ($clog2(GY)) |
| wr_en | input | 1 | Write strobe for a single grid word |
| wr_x | input | 5 | X coordinate of the word to write |
| wr_y | input | 5 | Y coordinate of the word to write |
| wr_data | input | 16 | Word to store |
| rd_valid | output | 1 | Marks the cycle in which `rd_data` holds a requested neighbourhood |
| rd_data | output | 256 | Sixteen words in cluster order, position p in bits p*16 +: 16 |

## Verification
The bench walks every combination of the two base low-bit pairs, so each bank sees the "next tile" choice on X alone, on Y alone and on both. A design that compared bank index against the low bits with the wrong sense, or rotated the outputs the wrong way, would return words shifted by a tile or mirrored inside the cluster. Writes are placed in the same cycle as a read and in the cycle just after it, targeting words inside that read's neighbourhood. A design with the wrong pipeline depth between address capture and RAM read would then return the new word where the old one is due, or the reverse. Full-grid readbacks follow a single overwrite and a stretch of disabled writes carrying junk coordinates and data. They catch a decoder that enables more than one bank or that ignores the write strobe.

// File: rtl/igc_pkg.sv
package igc_pkg;

   // Row or column of the bank-local store that a bank must read along one axis:
   // banks whose index lies below the base's low bits belong to the next tile.
   function automatic int axis_slot(input int hi, input int low, input int bank);
      return (bank < low) ? hi + 1 : hi;
   endfunction

   // True when n is a power of two no smaller than two.
   function automatic bit pow2_min2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/igc_addr_gen.sv
module igc_addr_gen #(
   parameter  int GX  = 32,
   parameter  int GY  = 32,
   parameter  int NBX = 4,
   parameter  int NBY = 4,
   localparam int XW  = $clog2(GX),
   localparam int YW  = $clog2(GY),
   localparam int LXW = $clog2(NBX),
   localparam int LYW = $clog2(NBY),
   localparam int NB  = NBX * NBY,
   localparam int AW  = $clog2((GX / NBX) * (GY / NBY))
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic [XW-1:0]          rd_x,
   input  logic [YW-1:0]          rd_y,
   output logic                   s1_valid,
   output logic [LXW-1:0]         s1_lx,
   output logic [LYW-1:0]         s1_ly,
   output logic [NB-1:0][AW-1:0]  s1_addr
);
   localparam int HXW = XW - LXW;
   localparam int HYW = YW - LYW;
   localparam int AXW = HXW + 1;
   localparam int AYW = HYW + 1;
   localparam int RY  = GY / NBY;

   logic [HXW-1:0] hx;
   logic [HYW-1:0] hy;
   logic [AXW-1:0] ax_d [NBX];
   logic [AXW-1:0] ax_q [NBX];
   logic [AYW-1:0] ay_d [NBY];
   logic [AYW-1:0] ay_q [NBY];

   assign hx = rd_x[XW-1:LXW];
   assign hy = rd_y[YW-1:LYW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_lx    <= '0;
         s1_ly    <= '0;
      end else begin
         s1_valid <= rd_en;
         if (rd_en) begin
            s1_lx <= rd_x[LXW-1:0];
            s1_ly <= rd_y[LYW-1:0];
         end
      end
   end

   // Per-column choice of tile, one register per bank column.
   for (genvar bx = 0; bx < NBX; bx++) begin : g_col
      always_comb ax_d[bx] = AXW'(igc_pkg::axis_slot(int'(hx), int'(rd_x[LXW-1:0]), bx));

      always_ff @(posedge clk) begin
         if (rd_en) ax_q[bx] <= ax_d[bx];
      end

      AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en |=> (ax_q[bx] == {1'b0, $past(hx)}) || (ax_q[bx] == {1'b0, $past(hx)} + 1'b1)); // R5

      AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && (rd_x[LXW-1:0] == '0)) |=> (ax_q[bx] == ax_q[0])); // R4
   end

   // Per-row choice of tile, one register per bank row.
   for (genvar by = 0; by < NBY; by++) begin : g_row
      always_comb ay_d[by] = AYW'(igc_pkg::axis_slot(int'(hy), int'(rd_y[LYW-1:0]), by));

      always_ff @(posedge clk) begin
         if (rd_en) ay_q[by] <= ay_d[by];
      end

      AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en |=> (ay_q[by] == {1'b0, $past(hy)}) || (ay_q[by] == {1'b0, $past(hy)} + 1'b1)); // R5

      AST_ROW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && (rd_y[LYW-1:0] == '0)) |=> (ay_q[by] == ay_q[0])); // R4
   end

   // Flatten only after the per-axis choice: column-major inside each bank.
   for (genvar b = 0; b < NB; b++) begin : g_flat
      assign s1_addr[b] = AW'(int'(ax_q[b % NBX]) * RY + int'(ay_q[b / NBX]));
   end

   AST_S1_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> s1_valid); // R2
   AST_S1_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !s1_valid); // R2

endmodule

// File: rtl/igc_bank_ram.sv
module igc_bank_ram #(
   parameter  int DW    = 16,
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   if (DEPTH < 2) begin : g_chk_depth
      $error("igc_bank_ram: DEPTH must be at least 2");
   end

   logic [DW-1:0] store [DEPTH];

   // Separate ports: the read sees the contents before a write on the same edge.
   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      rdata <= store[raddr];
   end

endmodule

// File: rtl/igc_deinterleave.sv
module igc_deinterleave #(
   parameter  int DW        = 16,
   parameter  int NBX       = 4,
   parameter  int NBY       = 4,
   parameter  bit TWO_LEVEL = 1'b1,
   localparam int LXW       = $clog2(NBX),
   localparam int LYW       = $clog2(NBY),
   localparam int NB        = NBX * NBY
) (
   input  logic [NB-1:0][DW-1:0] bank_q,
   input  logic [LXW-1:0]        lx,
   input  logic [LYW-1:0]        ly,
   output logic [NB-1:0][DW-1:0] cluster
);
   logic [LXW-1:0] sx [NBX];
   logic [LYW-1:0] sy [NBY];

   // Offsets wrap naturally because both bank counts are powers of two.
   for (genvar i = 0; i < NBX; i++) begin : g_sx
      assign sx[i] = lx + LXW'(i);
   end
   for (genvar j = 0; j < NBY; j++) begin : g_sy
      assign sy[j] = ly + LYW'(j);
   end

   if (TWO_LEVEL) begin : g_two_level
      // Rotate each bank row along X, then rotate the rows along Y.
      logic [DW-1:0] rowrot [NBY][NBX];
      for (genvar by = 0; by < NBY; by++) begin : g_rot_row
         for (genvar i = 0; i < NBX; i++) begin : g_rot_col
            assign rowrot[by][i] = bank_q[{LYW'(by), sx[i]}];
         end
      end
      for (genvar j = 0; j < NBY; j++) begin : g_out_row
         for (genvar i = 0; i < NBX; i++) begin : g_out_col
            assign cluster[i + NBX * j] = rowrot[sy[j]][i];
         end
      end
   end else begin : g_flat
      // One wide selector per output position.
      for (genvar j = 0; j < NBY; j++) begin : g_out_row
         for (genvar i = 0; i < NBX; i++) begin : g_out_col
            assign cluster[i + NBX * j] = bank_q[{sy[j], sx[i]}];
         end
      end
   end

endmodule

// File: rtl/igc_cluster_mem.sv
module igc_cluster_mem #(
   parameter  int GX            = 32,
   parameter  int GY            = 32,
   parameter  int DW            = 16,
   parameter  int NBX           = 4,
   parameter  int NBY           = 4,
   parameter  bit TWO_LEVEL_MUX = 1'b1,
   localparam int XW            = $clog2(GX),
   localparam int YW            = $clog2(GY),
   localparam int NB            = NBX * NBY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [XW-1:0]    rd_x,
   input  logic [YW-1:0]    rd_y,
   input  logic             wr_en,
   input  logic [XW-1:0]    wr_x,
   input  logic [YW-1:0]    wr_y,
   input  logic [DW-1:0]    wr_data,
   output logic             rd_valid,
   output logic [NB*DW-1:0] rd_data
);
   localparam int LXW   = $clog2(NBX);
   localparam int LYW   = $clog2(NBY);
   localparam int RX    = GX / NBX;
   localparam int RY    = GY / NBY;
   localparam int DEPTH = RX * RY;
   localparam int AW    = $clog2(DEPTH);

   // Elaboration-time parameter checks.
   if (!igc_pkg::pow2_min2(NBX) || !igc_pkg::pow2_min2(NBY)) begin : g_chk_banks
      $error("igc_cluster_mem: bank counts must be powers of two, at least 2");
   end
   if ((GX % NBX) != 0 || (GY % NBY) != 0) begin : g_chk_mult
      $error("igc_cluster_mem: grid size must be a multiple of the bank count per axis");
   end
   if (GX < 2 * NBX || GY < 2 * NBY) begin : g_chk_size
      $error("igc_cluster_mem: grid must span at least two tiles per axis");
   end
   if (DW < 1) begin : g_chk_dw
      $error("igc_cluster_mem: DW must be positive");
   end

   // Read address stage.
   logic                  s1_valid;
   logic [LXW-1:0]        s1_lx;
   logic [LYW-1:0]        s1_ly;
   logic [NB-1:0][AW-1:0] s1_addr;

   igc_addr_gen #(
      .GX (GX),
      .GY (GY),
      .NBX(NBX),
      .NBY(NBY)
   ) u_addr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_x    (rd_x),
      .rd_y    (rd_y),
      .s1_valid(s1_valid),
      .s1_lx   (s1_lx),
      .s1_ly   (s1_ly),
      .s1_addr (s1_addr)
   );

   // Write decode: one bank, one flattened address.
   logic [LXW+LYW-1:0] wbank;
   logic [AW-1:0]      waddr;
   logic [NB-1:0]      bank_we;

   assign wbank = {wr_y[LYW-1:0], wr_x[LXW-1:0]};
   assign waddr = AW'(int'(wr_x[XW-1:LXW]) * RY + int'(wr_y[YW-1:LYW]));

   for (genvar b = 0; b < NB; b++) begin : g_we
      assign bank_we[b] = wr_en && (wbank == (LXW + LYW)'(b));
   end

   AST_WR_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_we) == (wr_en ? 1 : 0)); // R6
   AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (bank_we == '0)); // R9

   // Bank array.
   logic [NB-1:0][DW-1:0] bank_q;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      igc_bank_ram #(
         .DW   (DW),
         .DEPTH(DEPTH)
      ) u_ram (
         .clk  (clk),
         .we   (bank_we[b]),
         .waddr(waddr),
         .wdata(wr_data),
         .raddr(s1_addr[b]),
         .rdata(bank_q[b])
      );
   end

   // RAM stage: carry the strobe and rotation amount alongside the read.
   logic           s2_valid;
   logic [LXW-1:0] s2_lx;
   logic [LYW-1:0] s2_ly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_lx    <= '0;
         s2_ly    <= '0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) begin
            s2_lx <= s1_lx;
            s2_ly <= s1_ly;
         end
      end
   end

   AST_OUT_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> rd_valid); // R2
   AST_OUT_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !rd_valid); // R2

   // Reorder bank outputs into cluster positions.
   logic [NB-1:0][DW-1:0] cluster;

   igc_deinterleave #(
      .DW       (DW),
      .NBX      (NBX),
      .NBY      (NBY),
      .TWO_LEVEL(TWO_LEVEL_MUX)
   ) u_deint (
      .bank_q (bank_q),
      .lx     (s2_lx),
      .ly     (s2_ly),
      .cluster(cluster)
   );

   assign rd_valid = s2_valid;

   for (genvar p = 0; p < NB; p++) begin : g_pack
      assign rd_data[p*DW +: DW] = cluster[p];
   end

endmodule

// File: tb/igc_cluster_mem_tb.sv
`timescale 1ns/1ps
module igc_cluster_mem_tb;
   localparam int GX   = 32;
   localparam int GY   = 32;
   localparam int DW   = 16;
   localparam int XW   = $clog2(GX);
   localparam int YW   = $clog2(GY);
   localparam int NPOS = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               rd_en = 1'b0;
   logic [XW-1:0]      rd_x = '0;
   logic [YW-1:0]      rd_y = '0;
   logic               wr_en = 1'b0;
   logic [XW-1:0]      wr_x = '0;
   logic [YW-1:0]      wr_y = '0;
   logic [DW-1:0]      wr_data = '0;
   logic               rd_valid;
   logic [NPOS*DW-1:0] rd_data;

   always #2 clk = ~clk;

   igc_cluster_mem #(.GX(GX), .GY(GY), .DW(DW)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_x    (rd_x),
      .rd_y    (rd_y),
      .wr_en   (wr_en),
      .wr_x    (wr_x),
      .wr_y    (wr_y),
      .wr_data (wr_data),
      .rd_valid(rd_valid),
      .rd_data (rd_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // Behavioural reference: grid contents and a two-deep expectation pipe.
   logic [DW-1:0]      grid [GX][GY];
   bit                 p1_v = 0, p2_v = 0;
   logic [NPOS*DW-1:0] p1_d, p2_d;
   int                 p1_x, p1_y, p2_x, p2_y;
   string              p1_tag = "", p2_tag = "";

   function automatic logic [DW-1:0] seed_val(input int x, input int y);
      return DW'((x * 131 + y * 7 + 16'h5A) & 16'hFFFF);
   endfunction

   function automatic logic [NPOS*DW-1:0] expect_cluster(input int x, input int y);
      logic [NPOS*DW-1:0] r;
      for (int j = 0; j < 4; j++)
         for (int i = 0; i < 4; i++)
            r[(i + 4 * j) * DW +: DW] = grid[x + i][y + j];
      return r;
   endfunction

   // One clock: check outputs, advance the model, drive the next inputs.
   task automatic step(input bit rd, input int x, input int y,
                       input bit wr, input int wx, input int wy,
                       input logic [DW-1:0] wd, input string tag);
      @(negedge clk);
      n_checks++;
      if (rd_valid !== p2_v) begin
         n_fail++;
         $display("FAIL R2 rd_valid actual %0b expected %0b", rd_valid, p2_v);
      end
      if (p2_v) begin
         n_checks++;
         if (rd_data !== p2_d) begin
            n_fail++;
            for (int p = 0; p < NPOS; p++) begin
               if (rd_data[p*DW +: DW] !== p2_d[p*DW +: DW]) begin
                  $display("FAIL %s base (%0d,%0d) pos %0d actual %h expected %h",
                           p2_tag, p2_x, p2_y, p, rd_data[p*DW +: DW], p2_d[p*DW +: DW]);
                  break;
               end
            end
         end
      end
      p2_v = p1_v; p2_d = p1_d; p2_x = p1_x; p2_y = p1_y; p2_tag = p1_tag;
      if (wr) grid[wx][wy] = wd;
      p1_v = rd; p1_x = x; p1_y = y; p1_tag = tag;
      if (rd) p1_d = expect_cluster(x, y);
      rd_en   = rd;
      rd_x    = XW'(x);
      rd_y    = YW'(y);
      wr_en   = wr;
      wr_x    = XW'(wx);
      wr_y    = YW'(wy);
      wr_data = wd;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, '0, "R2");
   endtask

   task automatic read_all_tiles(input string tag);
      for (int tx = 0; tx < GX / 4; tx++)
         for (int ty = 0; ty < GY / 4; ty++)
            step(1, 4 * tx, 4 * ty, 0, 0, 0, '0, tag);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      // R1: valid low while held in reset.
      repeat (3) @(negedge clk);
      n_checks++;
      if (rd_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 rd_valid in reset actual %0b expected 0", rd_valid);
      end
      rst_n = 1'b1;
      // R1: and stays low after release with no request.
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         n_checks++;
         if (rd_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 rd_valid after reset actual %0b expected 0", rd_valid);
         end
      end

      // Load the whole grid one word at a time.
      for (int x = 0; x < GX; x++)
         for (int y = 0; y < GY; y++)
            step(0, 0, 0, 1, x, y, seed_val(x, y), "R6");
      idle(2);

      // R4: aligned tiles back to back (also exercises R3 ordering).
      read_all_tiles("R4");
      idle(3);

      // R5: every low-bit pair, at several tile positions.
      for (int lx = 0; lx < 4; lx++)
         for (int ly = 0; ly < 4; ly++)
            for (int h = 0; h < 3; h++)
               step(1, 4 * (h * 3) + lx > GX - 4 ? GX - 4 : 4 * (h * 3) + lx,
                       4 * (h * 2 + 1) + ly > GY - 4 ? GY - 4 : 4 * (h * 2 + 1) + ly,
                       0, 0, 0, '0, "R5");
      idle(2);

      // R3: random in-grid bases, with gaps to vary the valid pattern.
      for (int k = 0; k < 200; k++) begin
         step(1, $urandom_range(GX - 4, 0), $urandom_range(GY - 4, 0), 0, 0, 0, '0, "R3");
         if ((k % 7) == 3) idle(1);
      end
      idle(2);

      // R8: same-cycle write is seen; a write one cycle later is not.
      step(1, 9, 9, 1, 10, 11, 16'hBEEF, "R8");
      step(1, 5, 6, 0, 0, 0, '0, "R8");
      step(0, 0, 0, 1, 6, 7, 16'hCAFE, "R8");
      step(1, 5, 6, 0, 0, 0, '0, "R8");
      idle(3);

      // R7: reads and writes together every cycle.
      for (int k = 0; k < 150; k++)
         step(1, $urandom_range(GX - 4, 0), $urandom_range(GY - 4, 0),
              1, $urandom_range(GX - 1, 0), $urandom_range(GY - 1, 0),
              DW'($urandom), "R7");
      idle(3);

      // R6: overwrite one word, then confirm the whole grid.
      step(0, 0, 0, 1, 13, 22, 16'h1234, "R6");
      read_all_tiles("R6");
      idle(3);

      // R9: junk on the write port with the strobe low, then confirm the grid.
      for (int k = 0; k < 40; k++)
         step(1, $urandom_range(GX - 4, 0), $urandom_range(GY - 4, 0),
              0, $urandom_range(GX - 1, 0), $urandom_range(GY - 1, 0),
              DW'($urandom), "R9");
      read_all_tiles("R9");
      idle(4);

      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
   end

endmodule